// File: doc/BRIEF.md
# Hardware System-Call Resolver

This block sits inside a small in-order scalar core and finishes selected operating-system calls without leaving the pipeline. When the core retires a SYSCALL instruction, it raises `sys_valid` for one cycle and presents the instruction's address and the current value of register $v1. The block uses that value as the call number. If the number is in a fixed table of eleven entries, the block completes the call in one step. It writes a zero return value into $v0 through both the 32-bit register-file port and the 128-bit shadow-register port. It then loads the program counter with the next instruction address, pulses the retire strobe and asks the core to fetch again.

A number outside the table stops the core. The block raises `halted` and latches the faulting instruction address and call number for software-independent diagnosis. It keeps them until reset, and any later call request is ignored. The four argument registers are captured onto a debug port for observation only. They never influence what is written back.

Top module: `sysemu_dispatch`

## Requirements
- R1: The call number is the full 32-bit `call_num` input (the $v1 value). A value differing from a table entry in any bit, including the upper bits, counts as unknown.
- R2: For a known call, `rf_we` is high in the cycle after `sys_valid`, with `rf_waddr` = 2 and `rf_wdata` = 0.
- R3: In the same cycle as the R2 write, `sh_we` is high with `sh_waddr` = 2 and `sh_wdata` = 128'h0.
- R4: In the same cycle, `pc_we` is high and `pc_next` equals the SYSCALL address plus 4.
- R5: `retire` and `fetch_req` are high for exactly one cycle per known call, in the same cycle as the R2 write.
- R6: For an unknown call, `halted` rises in the cycle after `sys_valid`. No write, PC update or retire occurs for that call.
- R7: Once halted, `halt_pc` and `halt_num` keep the faulting address and number until reset. Further `sys_valid` pulses cause no write, no retire and no change to `dbg_args`.
- R8: `dbg_args` shows `call_args` ({$a3,$a2,$a1,$a0}, $a0 in bits 31:0) captured with each accepted call, one cycle after `sys_valid`. The argument values do not change any write-back value.
- R9: While reset is asserted and after it is released, `halted`, `retire`, `fetch_req`, `rf_we`, `sh_we` and `pc_we` are low.
- R10: Each known call makes exactly one register-file write, and register 0 is never written.
- R11: The default table holds the eleven numbers 0x02, 0x04, 0x05, 0x12, 0x13, 0x3C, 0x3D, 0x40, 0x64, 0x6B and 0x77, and each of them is resolved as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_valid | input | 1 | SYSCALL retiring this cycle |
| sys_pc | input | 32 | Address of the SYSCALL |
| call_num | input | 32 | Value of $v1 |
| call_args | input | 128 | {$a3,$a2,$a1,$a0} |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| sh_we | output | 1 | Shadow-register write enable |
| sh_waddr | output | 5 | Shadow-register write index |
| sh_wdata | output | 128 | Shadow-register write data |
| pc_we | output | 1 | PC load enable |
| pc_next | output | 32 | New PC value |
| retire | output | 1 | One-cycle retire strobe |
| fetch_req | output | 1 | Return to instruction fetch |
| halted | output | 1 | Unknown call seen; core stopped |
| halt_pc | output | 32 | Address of the faulting SYSCALL |
| halt_num | output | 32 | Unsupported call number |
| dbg_args | output | 128 | Captured arguments (observation only) |

## Verification
Every result is due exactly one clock edge after the `sys_valid` cycle. This covers the two write ports, the PC load, the retire and fetch strobes, the halt flag with its latched fields, and the captured arguments. The driver pushes the expected outcome into a queue on the falling edge where it raises `sys_valid`. The monitor samples on the following falling edge, when the registered outputs have settled. It pops one item for each retire or halt and reports any strobe that arrives with an empty queue. After a halt, the monitor watches further ignored pulses for several cycles before the bench resets the block and confirms that the table works again.

// File: rtl/sysemu_pkg.sv
package sysemu_pkg;
  localparam int XLEN     = 32;
  localparam int SHADOW_W = 128;
  localparam int RIDX_W   = 5;
  localparam logic [RIDX_W-1:0] RET_REG = 5'd2;

  typedef enum logic {DS_RUN = 1'b0, DS_STOP = 1'b1} disp_state_e;

  function automatic logic [XLEN-1:0] pc_after_call(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] ret_value32();
    return '0;
  endfunction

  function automatic logic [SHADOW_W-1:0] ret_value128();
    return {{(SHADOW_W-XLEN){1'b0}}, ret_value32()};
  endfunction
endpackage

// File: rtl/sysemu_call_table.sv
module sysemu_call_table #(
  parameter int N_CALLS = 11,
  parameter int NUM_W   = 32,
  parameter logic [N_CALLS*NUM_W-1:0] TABLE = '0
) (
  input  logic [NUM_W-1:0] key,
  output logic             hit
);
  logic [N_CALLS-1:0] entry_eq;

  for (genvar i = 0; i < N_CALLS; i++) begin : g_entry
    assign entry_eq[i] = (key == TABLE[i*NUM_W +: NUM_W]);
  end

  assign hit = |entry_eq;
endmodule

// File: rtl/sysemu_writeback.sv
module sysemu_writeback
  import sysemu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [XLEN-1:0]     pc_in,
  output logic                rf_we,
  output logic [RIDX_W-1:0]   rf_waddr,
  output logic [XLEN-1:0]     rf_wdata,
  output logic                sh_we,
  output logic [RIDX_W-1:0]   sh_waddr,
  output logic [SHADOW_W-1:0] sh_wdata,
  output logic                pc_we,
  output logic [XLEN-1:0]     pc_next,
  output logic                retire,
  output logic                fetch_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      sh_we     <= 1'b0;
      sh_waddr  <= '0;
      sh_wdata  <= '0;
      pc_we     <= 1'b0;
      pc_next   <= '0;
      retire    <= 1'b0;
      fetch_req <= 1'b0;
    end else begin
      rf_we     <= fire;
      sh_we     <= fire;
      pc_we     <= fire;
      retire    <= fire;
      fetch_req <= fire;
      if (fire) begin
        rf_waddr <= RET_REG;
        rf_wdata <= ret_value32();
        sh_waddr <= RET_REG;
        sh_wdata <= ret_value128();
        pc_next  <= pc_after_call(pc_in);
      end
    end
  end
endmodule

// File: rtl/sysemu_dispatch.sv
module sysemu_dispatch
  import sysemu_pkg::*;
#(
  parameter int N_CALLS = 11,
  parameter int N_ARGS  = 4,
  parameter logic [N_CALLS*XLEN-1:0] CALL_TABLE = {
    32'h0000_0077, 32'h0000_006B, 32'h0000_0064, 32'h0000_0040,
    32'h0000_003D, 32'h0000_003C, 32'h0000_0013, 32'h0000_0012,
    32'h0000_0005, 32'h0000_0004, 32'h0000_0002}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sys_valid,
  input  logic [XLEN-1:0]        sys_pc,
  input  logic [XLEN-1:0]        call_num,
  input  logic [N_ARGS*XLEN-1:0] call_args,
  output logic                   rf_we,
  output logic [RIDX_W-1:0]      rf_waddr,
  output logic [XLEN-1:0]        rf_wdata,
  output logic                   sh_we,
  output logic [RIDX_W-1:0]      sh_waddr,
  output logic [SHADOW_W-1:0]    sh_wdata,
  output logic                   pc_we,
  output logic [XLEN-1:0]        pc_next,
  output logic                   retire,
  output logic                   fetch_req,
  output logic                   halted,
  output logic [XLEN-1:0]        halt_pc,
  output logic [XLEN-1:0]        halt_num,
  output logic [N_ARGS*XLEN-1:0] dbg_args
);
  disp_state_e state_q;

  // Named internal events for the checker
  logic call_accept;
  logic call_hit;
  logic call_ok;
  logic call_bad;

  sysemu_call_table #(
    .N_CALLS (N_CALLS),
    .NUM_W   (XLEN),
    .TABLE   (CALL_TABLE)
  ) u_table (
    .key (call_num),
    .hit (call_hit)
  );

  assign call_accept = sys_valid && (state_q == DS_RUN);
  assign call_ok     = call_accept && call_hit;
  assign call_bad    = call_accept && !call_hit;

  sysemu_writeback u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (call_ok),
    .pc_in     (sys_pc),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .sh_we     (sh_we),
    .sh_waddr  (sh_waddr),
    .sh_wdata  (sh_wdata),
    .pc_we     (pc_we),
    .pc_next   (pc_next),
    .retire    (retire),
    .fetch_req (fetch_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= DS_RUN;
      halt_pc  <= '0;
      halt_num <= '0;
      dbg_args <= '0;
    end else begin
      if (call_accept) dbg_args <= call_args;
      if (call_bad) begin
        state_q  <= DS_STOP;
        halt_pc  <= sys_pc;
        halt_num <= call_num;
      end
    end
  end

  assign halted = (state_q == DS_STOP);
endmodule

// File: rtl/sysemu_dispatch_chk.sv
module sysemu_dispatch_chk
  import sysemu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sys_valid,
  input logic [XLEN-1:0]   sys_pc,
  input logic              call_accept,
  input logic              call_hit,
  input logic              rf_we,
  input logic [RIDX_W-1:0] rf_waddr,
  input logic              sh_we,
  input logic              pc_we,
  input logic [XLEN-1:0]   pc_next,
  input logic              retire,
  input logic              fetch_req,
  input logic              halted,
  input logic [XLEN-1:0]   halt_pc,
  input logic [XLEN-1:0]   halt_num
);
  assert_known_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    call_accept && call_hit |=> rf_we);

  assert_shadow_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> sh_we);

  assert_pc_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> pc_next == $past(sys_pc) + 32'd4);

  assert_retire_caused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(sys_valid) && fetch_req && rf_we);

  assert_unknown_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_accept && !call_hit |=> halted && !retire && !rf_we);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halted) |-> halted && $stable(halt_pc) && $stable(halt_num));

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted && $past(halted) |-> !retire && !rf_we && !pc_we);

  assert_no_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != '0);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> !halted && !retire);
endmodule

bind sysemu_dispatch sysemu_dispatch_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_valid   (sys_valid),
  .sys_pc      (sys_pc),
  .call_accept (call_accept),
  .call_hit    (call_hit),
  .rf_we       (rf_we),
  .rf_waddr    (rf_waddr),
  .sh_we       (sh_we),
  .pc_we       (pc_we),
  .pc_next     (pc_next),
  .retire      (retire),
  .fetch_req   (fetch_req),
  .halted      (halted),
  .halt_pc     (halt_pc),
  .halt_num    (halt_num)
);

// File: tb/sysemu_dispatch_tb.sv
`timescale 1ns/1ps
module sysemu_dispatch_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sys_valid = 1'b0;
  logic [31:0]  sys_pc = '0;
  logic [31:0]  call_num = '0;
  logic [127:0] call_args = '0;
  logic         rf_we, sh_we, pc_we, retire, fetch_req, halted;
  logic [4:0]   rf_waddr, sh_waddr;
  logic [31:0]  rf_wdata, pc_next, halt_pc, halt_num;
  logic [127:0] sh_wdata, dbg_args;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  bit halt_seen = 1'b0;
  bit prev_retire = 1'b0;

  typedef struct {
    bit           stop;
    logic [31:0]  pc;
    logic [31:0]  num;
    logic [127:0] args;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  sysemu_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .sys_valid(sys_valid), .sys_pc(sys_pc),
    .call_num(call_num), .call_args(call_args),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .sh_we(sh_we), .sh_waddr(sh_waddr), .sh_wdata(sh_wdata),
    .pc_we(pc_we), .pc_next(pc_next), .retire(retire), .fetch_req(fetch_req),
    .halted(halted), .halt_pc(halt_pc), .halt_num(halt_num), .dbg_args(dbg_args)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Driver: queue the expected outcome, then pulse sys_valid for one cycle
  task automatic do_call(input logic [31:0] pc, input logic [31:0] num,
                         input logic [127:0] args, input bit known, input bit expect_any);
    exp_t e;
    @(negedge clk);
    e.stop = !known; e.pc = pc; e.num = num; e.args = args;
    if (expect_any) q.push_back(e);
    sys_pc = pc; call_num = num; call_args = args; sys_valid = 1'b1;
    @(negedge clk);
    sys_valid = 1'b0;
    call_args = ~args;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: results are due one edge after sys_valid, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      halt_seen   = 1'b0;
      prev_retire = 1'b0;
    end else if (!done) begin
      exp_t e;
      if (prev_retire)
        chk(!retire, "R5 single-cycle retire", 128'(retire), 128'd0);
      if (retire) begin
        if (q.size() == 0) chk(1'b0, "R5 unexpected retire", 128'd1, 128'd0);
        else begin
          e = q.pop_front();
          chk(!e.stop, "R6 retire on unknown call", 128'd1, 128'd0);
          chk(rf_we && rf_waddr == 5'd2 && rf_wdata == 32'd0, "R2 v0 write",
              {rf_we, rf_waddr, rf_wdata}, {1'b1, 5'd2, 32'd0});
          chk(sh_we && sh_waddr == 5'd2 && sh_wdata == '0, "R3 shadow write",
              {sh_we, sh_waddr}, {1'b1, 5'd2});
          chk(pc_we && pc_next == e.pc + 32'd4, "R4 pc advance",
              128'(pc_next), 128'(e.pc + 32'd4));
          chk(fetch_req, "R5 fetch request", 128'(fetch_req), 128'd1);
          chk(dbg_args == e.args, "R8 debug args", dbg_args, e.args);
        end
      end
      if (halted && !halt_seen) begin
        halt_seen = 1'b1;
        if (q.size() == 0) chk(1'b0, "R6 unexpected halt", 128'd1, 128'd0);
        else begin
          e = q.pop_front();
          chk(e.stop, "R1 halt on known call", 128'(e.num), 128'd0);
          chk(halt_pc == e.pc, "R6 halt pc", 128'(halt_pc), 128'(e.pc));
          chk(halt_num == e.num, "R6 halt number", 128'(halt_num), 128'(e.num));
          chk(!rf_we && !pc_we && !retire, "R6 no write on unknown",
              {rf_we, pc_we, retire}, 128'd0);
        end
      end
      if (rf_we && !retire) chk(1'b0, "R10 stray write", 128'd1, 128'd0);
      if (rf_we) chk(rf_waddr != 5'd0, "R10 gpr0 write", 128'(rf_waddr), 128'd2);
      prev_retire = retire;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 128'd0, 128'd1);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    chk(!halted && !retire && !rf_we && !sh_we && !pc_we && !fetch_req,
        "R9 outputs in reset", {halted, retire, rf_we, sh_we, pc_we, fetch_req}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!halted && !retire && !rf_we, "R9 outputs after reset",
        {halted, retire, rf_we}, 128'd0);
  endtask

  initial begin
    logic [31:0] tbl [11];
    logic [31:0] keep_pc, keep_num;
    logic [127:0] keep_args;
    tbl = '{32'h02, 32'h04, 32'h05, 32'h12, 32'h13, 32'h3C, 32'h3D,
            32'h40, 32'h64, 32'h6B, 32'h77};
    do_reset();

    // R11: every table entry resolves; R8: varied arguments
    for (int i = 0; i < 11; i++)
      do_call(32'h0011_0000 + 32'(i * 8), tbl[i],
              {32'(i), 32'hFFFF_FFFF, 32'hA5A5_0000 + 32'(i), 32'd5}, 1'b1, 1'b1);

    // R8: same number, different arguments, same write-back
    do_call(32'h0011_1D64, 32'h6B, {32'h0013_7568, 32'hFFFF_FFFF, 32'd0, 32'd5}, 1'b1, 1'b1);
    do_call(32'h0011_1D68, 32'h6B, 128'd0, 1'b1, 1'b1);
    // R4: PC wrap at top of address space
    do_call(32'hFFFF_FFFC, 32'h13, 128'h1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R5 all known calls retired", 128'(q.size()), 128'd0);

    // R1: upper bits set make the number unknown
    do_call(32'h0011_0A60, 32'h1000_006B, 128'hBEEF, 1'b0, 1'b1);
    chk(halted, "R6 halted", 128'(halted), 128'd1);
    keep_pc = halt_pc; keep_num = halt_num; keep_args = dbg_args;

    // R7: later calls ignored, halt fields held
    do_call(32'h0022_0000, 32'h6B, 128'h1234, 1'b1, 1'b0);
    do_call(32'h0022_0004, 32'h99, 128'h5678, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(halted && halt_pc == keep_pc && halt_num == keep_num, "R7 halt held",
        {halted, halt_pc, halt_num}, {1'b1, keep_pc, keep_num});
    chk(dbg_args == keep_args, "R7 args frozen", dbg_args, keep_args);

    // R9: reset clears halt; table works again
    do_reset();
    do_call(32'h0000_1000, 32'h6B, 128'h7, 1'b1, 1'b1);
    // Boundary: number 0 is not in the table
    do_call(32'h0000_2000, 32'h0, 128'h9, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R6 scoreboard drained", 128'(q.size()), 128'd0);
    finish_run();
  end
endmodule